// File: doc/BRIEF.md
# Two-Pass Truncated-Pixel Block Motion Estimator

This block finds the best-matching position of one square block of current-frame pixels inside a square reference search window. The match cost of a candidate displacement is the sum of absolute differences (SAD) between every current pixel and the reference pixel at the same offset inside the displaced block. It evaluates one candidate per clock. It asks for each candidate by driving a signed row/column displacement. In the same cycle the surrounding logic must return the reference pixels of that candidate on a flat bus.

In the default two-pass mode the block first scans the whole window with every pixel cut to its two most significant bits. It then runs an 8-bit refinement over a small window around the coarse winner. One set of absolute-difference lanes, one adder tree and one minimum tracker serve both passes. Only a pixel mask changes between them. A second mode skips the coarse pass and runs one full-resolution scan over the whole window.

At the end the block reports the winning displacement, its 8-bit cost and a flag set when that cost exceeds a threshold. A one-cycle done pulse marks the end, and the results stay fixed until the next search ends.

Top module: `me_two_step`

## Requirements
- R1: `cost_o` equals the smallest 8-bit SAD among the candidates of the final pass, and `mv_row_o`/`mv_col_o` give that candidate's displacement. Pixel (r,c) of a block, r and c from 0 to BLK-1, sits in lane r*BLK+c at bits [8*lane +: 8] of `cur_blk_i` and `ref_blk_i`. Reference pixel (r,c) of candidate (dy,dx) is window pixel (RANGE+dy+r, RANGE+dx+c).
- R2: With `mode_i`=0 the coarse pass visits every displacement from -RANGE to +RANGE. Rows are the outer loop, both in ascending order. Each pixel of both blocks is ANDed with 0xC0 before the difference, so the low six bits never change the coarse winner.
- R3: The refinement pass visits rows from max(wr-2,-RANGE) to min(wr+2,RANGE), and columns by the same rule on wc, in raster order. (wr,wc) is the coarse winner. No requested displacement ever leaves [-RANGE, RANGE].
- R4: With `mode_i`=1 a single 8-bit pass covers the whole window in raster order, with no coarse pass.
- R5: When candidates have equal cost, the one visited first in a pass wins.
- R6: `not_found_o` is 1 exactly when the final cost is strictly greater than the `thresh_i` value sampled with `start_i`.
- R7: `done_o` is high for exactly one cycle, N cycles after the edge that samples `start_i`, where N is the total number of candidates. The results change only on that cycle. A `start_i` raised during a search has no effect.
- R8: After reset, `cand_vld_o`, `done_o`, `not_found_o`, `cost_o` and the motion vector are all zero.
- R9: `cand_vld_o` is high exactly on the cycles in which a candidate is being evaluated. The first candidate appears on the cycle after `start_i` is sampled, and a new one follows every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a search when idle |
| mode_i | input | 1 | 0: two-pass, 1: full-resolution single pass |
| thresh_i | input | COST_W | Not-found threshold |
| cur_blk_i | input | BLK*BLK*8 | Current block pixels, sampled at start |
| ref_blk_i | input | BLK*BLK*8 | Reference pixels of the requested candidate |
| cand_vld_o | output | 1 | Candidate request active |
| cand_row_o | output | MV_W | Requested row displacement (signed) |
| cand_col_o | output | MV_W | Requested column displacement (signed) |
| done_o | output | 1 | One-cycle end-of-search pulse |
| mv_row_o | output | MV_W | Winning row displacement (signed) |
| mv_col_o | output | MV_W | Winning column displacement (signed) |
| cost_o | output | COST_W | Winning 8-bit SAD |
| not_found_o | output | 1 | Cost above threshold |

## Verification
The first candidate request appears one cycle after the edge that samples `start_i`. Each later request follows one cycle after the one before it. Results and `done_o` land on the cycle after the last candidate, which is N cycles after the start edge. The bench model builds the exact list of candidates from the frame data before the search runs. It then compares the request, `cand_vld_o` and `done_o` on every falling edge, at the index the cycle count gives. The results are compared on the cycle that follows the last listed candidate. They are compared again after some idle cycles to confirm that they hold.

// File: rtl/me_pkg.sv
package me_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COARSE = 2'd1,
    ST_FINE   = 2'd2
  } me_state_e;

  function automatic int clip_lo(int w, int rad, int rng);
    return (w - rad < -rng) ? -rng : w - rad;
  endfunction

  function automatic int clip_hi(int w, int rad, int rng);
    return (w + rad > rng) ? rng : w + rad;
  endfunction

endpackage

// File: rtl/me_absdiff_lanes.sv
module me_absdiff_lanes #(
  parameter int unsigned NUM      = 16,
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned KEEP_MSB = 2
) (
  input  logic [NUM*PIX_W-1:0] cur_i,
  input  logic [NUM*PIX_W-1:0] ref_i,
  input  logic                 lowres_i,
  output logic [NUM*PIX_W-1:0] diff_o
);
  localparam logic [PIX_W-1:0] TRUNC_MASK = {PIX_W{1'b1}} << (PIX_W - KEEP_MSB);

  logic [PIX_W-1:0] mask;
  assign mask = lowres_i ? TRUNC_MASK : {PIX_W{1'b1}};

  for (genvar i = 0; i < NUM; i++) begin : g_lane
    logic [PIX_W-1:0] a, b;
    assign a = cur_i[i*PIX_W +: PIX_W] & mask;
    assign b = ref_i[i*PIX_W +: PIX_W] & mask;
    assign diff_o[i*PIX_W +: PIX_W] = (a > b) ? (a - b) : (b - a);
  end
endmodule

// File: rtl/me_adder_tree.sv
module me_adder_tree #(
  parameter int unsigned NUM   = 16,
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 12
) (
  input  logic [NUM*IN_W-1:0] in_i,
  output logic [OUT_W-1:0]    sum_o
);
  localparam int unsigned LVLS = $clog2(NUM);

  for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int unsigned CNT = NUM >> l;
    logic [OUT_W-1:0] sums [CNT];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < CNT; j++) begin : g_n
        assign sums[j] = OUT_W'(in_i[j*IN_W +: IN_W]);
      end
    end else begin : g_add
      for (genvar j = 0; j < CNT; j++) begin : g_n
        assign sums[j] = g_lvl[l-1].sums[2*j] + g_lvl[l-1].sums[2*j+1];
      end
    end
  end

  assign sum_o = g_lvl[LVLS].sums[0];
endmodule

// File: rtl/me_scan.sv
module me_scan #(
  parameter int unsigned MV_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   step_i,
  input  logic signed [MV_W-1:0] row_lo_i,
  input  logic signed [MV_W-1:0] row_hi_i,
  input  logic signed [MV_W-1:0] col_lo_i,
  input  logic signed [MV_W-1:0] col_hi_i,
  output logic signed [MV_W-1:0] row_o,
  output logic signed [MV_W-1:0] col_o,
  output logic                   last_o
);
  logic signed [MV_W-1:0] row_q, col_q, row_hi_q, col_lo_q, col_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q    <= '0;
      col_q    <= '0;
      row_hi_q <= '0;
      col_lo_q <= '0;
      col_hi_q <= '0;
    end else if (load_i) begin
      row_q    <= row_lo_i;
      col_q    <= col_lo_i;
      row_hi_q <= row_hi_i;
      col_lo_q <= col_lo_i;
      col_hi_q <= col_hi_i;
    end else if (step_i) begin
      if (col_q == col_hi_q) begin
        col_q <= col_lo_q;
        row_q <= row_q + MV_W'(1);
      end else begin
        col_q <= col_q + MV_W'(1);
      end
    end
  end

  assign row_o  = row_q;
  assign col_o  = col_q;
  assign last_o = (row_q == row_hi_q) && (col_q == col_hi_q);
endmodule

// File: rtl/me_min_track.sv
module me_min_track #(
  parameter int unsigned COST_W = 12,
  parameter int unsigned MV_W   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   en_i,
  input  logic [COST_W-1:0]      cost_i,
  input  logic signed [MV_W-1:0] row_i,
  input  logic signed [MV_W-1:0] col_i,
  output logic [COST_W-1:0]      nxt_cost_o,
  output logic signed [MV_W-1:0] nxt_row_o,
  output logic signed [MV_W-1:0] nxt_col_o
);
  logic [COST_W-1:0]      best_cost_q;
  logic signed [MV_W-1:0] best_row_q, best_col_q;
  logic                   best_vld_q;
  logic                   take;

  // strict compare keeps the earliest candidate on ties
  assign take       = en_i && (!best_vld_q || (cost_i < best_cost_q));
  assign nxt_cost_o = take ? cost_i : best_cost_q;
  assign nxt_row_o  = take ? row_i  : best_row_q;
  assign nxt_col_o  = take ? col_i  : best_col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_cost_q <= '0;
      best_row_q  <= '0;
      best_col_q  <= '0;
      best_vld_q  <= 1'b0;
    end else if (clear_i) begin
      best_vld_q  <= 1'b0;
    end else if (en_i) begin
      best_cost_q <= nxt_cost_o;
      best_row_q  <= nxt_row_o;
      best_col_q  <= nxt_col_o;
      best_vld_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/me_two_step.sv
module me_two_step #(
  parameter int unsigned BLK      = 4,
  parameter int unsigned RANGE    = 4,
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned KEEP_MSB = 2,
  parameter int unsigned REF_RAD  = 2,
  localparam int unsigned NUM     = BLK * BLK,
  localparam int unsigned COST_W  = PIX_W + $clog2(NUM),
  localparam int unsigned MV_W    = $clog2(RANGE + 1) + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   mode_i,
  input  logic [COST_W-1:0]      thresh_i,
  input  logic [NUM*PIX_W-1:0]   cur_blk_i,
  input  logic [NUM*PIX_W-1:0]   ref_blk_i,
  output logic                   cand_vld_o,
  output logic signed [MV_W-1:0] cand_row_o,
  output logic signed [MV_W-1:0] cand_col_o,
  output logic                   done_o,
  output logic signed [MV_W-1:0] mv_row_o,
  output logic signed [MV_W-1:0] mv_col_o,
  output logic [COST_W-1:0]      cost_o,
  output logic                   not_found_o
);
  import me_pkg::*;

  localparam logic signed [MV_W-1:0] WIN_LO = -MV_W'(RANGE);
  localparam logic signed [MV_W-1:0] WIN_HI = MV_W'(RANGE);

  me_state_e              state_q;
  logic [NUM*PIX_W-1:0]   cur_q;
  logic [COST_W-1:0]      thresh_q;
  logic [NUM*PIX_W-1:0]   diff;
  logic [COST_W-1:0]      sad;
  logic                   lowres;
  logic                   scan_load, scan_step, scan_last;
  logic signed [MV_W-1:0] scan_row, scan_col;
  logic signed [MV_W-1:0] row_lo, row_hi, col_lo, col_hi;
  logic                   trk_clear, trk_en;
  logic [COST_W-1:0]      nxt_cost;
  logic signed [MV_W-1:0] nxt_row, nxt_col;

  assign lowres = (state_q == ST_COARSE);

  me_absdiff_lanes #(.NUM(NUM), .PIX_W(PIX_W), .KEEP_MSB(KEEP_MSB)) u_lanes (
    .cur_i    (cur_q),
    .ref_i    (ref_blk_i),
    .lowres_i (lowres),
    .diff_o   (diff)
  );

  me_adder_tree #(.NUM(NUM), .IN_W(PIX_W), .OUT_W(COST_W)) u_tree (
    .in_i  (diff),
    .sum_o (sad)
  );

  me_scan #(.MV_W(MV_W)) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (scan_load),
    .step_i   (scan_step),
    .row_lo_i (row_lo),
    .row_hi_i (row_hi),
    .col_lo_i (col_lo),
    .col_hi_i (col_hi),
    .row_o    (scan_row),
    .col_o    (scan_col),
    .last_o   (scan_last)
  );

  me_min_track #(.COST_W(COST_W), .MV_W(MV_W)) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (trk_clear),
    .en_i       (trk_en),
    .cost_i     (sad),
    .row_i      (scan_row),
    .col_i      (scan_col),
    .nxt_cost_o (nxt_cost),
    .nxt_row_o  (nxt_row),
    .nxt_col_o  (nxt_col)
  );

  always_comb begin
    scan_load = 1'b0;
    scan_step = 1'b0;
    trk_clear = 1'b0;
    trk_en    = 1'b0;
    row_lo    = WIN_LO;
    row_hi    = WIN_HI;
    col_lo    = WIN_LO;
    col_hi    = WIN_HI;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          scan_load = 1'b1;
          trk_clear = 1'b1;
        end
      end
      ST_COARSE: begin
        trk_en = 1'b1;
        if (scan_last) begin
          // refinement window around the coarse winner, clipped to the search window
          scan_load = 1'b1;
          trk_clear = 1'b1;
          row_lo = MV_W'(clip_lo(int'(nxt_row), int'(REF_RAD), int'(RANGE)));
          row_hi = MV_W'(clip_hi(int'(nxt_row), int'(REF_RAD), int'(RANGE)));
          col_lo = MV_W'(clip_lo(int'(nxt_col), int'(REF_RAD), int'(RANGE)));
          col_hi = MV_W'(clip_hi(int'(nxt_col), int'(REF_RAD), int'(RANGE)));
        end else begin
          scan_step = 1'b1;
        end
      end
      ST_FINE: begin
        trk_en    = 1'b1;
        scan_step = !scan_last;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      thresh_q    <= '0;
      done_o      <= 1'b0;
      mv_row_o    <= '0;
      mv_col_o    <= '0;
      cost_o      <= '0;
      not_found_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cur_q    <= cur_blk_i;
            thresh_q <= thresh_i;
            state_q  <= mode_i ? ST_FINE : ST_COARSE;
          end
        end
        ST_COARSE: begin
          if (scan_last) state_q <= ST_FINE;
        end
        ST_FINE: begin
          if (scan_last) begin
            state_q     <= ST_IDLE;
            done_o      <= 1'b1;
            mv_row_o    <= nxt_row;
            mv_col_o    <= nxt_col;
            cost_o      <= nxt_cost;
            not_found_o <= (nxt_cost > thresh_q);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cand_vld_o = (state_q != ST_IDLE);
  assign cand_row_o = scan_row;
  assign cand_col_o = scan_col;
endmodule

// File: rtl/me_two_step_chk.sv
module me_two_step_chk #(
  parameter int unsigned RANGE  = 4,
  parameter int unsigned MV_W   = 4,
  parameter int unsigned COST_W = 12
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cand_vld_o,
  input logic signed [MV_W-1:0] cand_row_o,
  input logic signed [MV_W-1:0] cand_col_o,
  input logic                   done_o,
  input logic signed [MV_W-1:0] mv_row_o,
  input logic signed [MV_W-1:0] mv_col_o,
  input logic [COST_W-1:0]      cost_o,
  input logic                   not_found_o
);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_result_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(cost_o) && $stable(mv_row_o) && $stable(mv_col_o) && $stable(not_found_o)));

  p_cand_in_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_vld_o |-> (int'(cand_row_o) >= -int'(RANGE) && int'(cand_row_o) <= int'(RANGE) &&
                    int'(cand_col_o) >= -int'(RANGE) && int'(cand_col_o) <= int'(RANGE)));

  p_idle_at_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cand_vld_o);

  p_raster_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_vld_o && $past(cand_vld_o) && cand_row_o == $past(cand_row_o))
      |-> int'(cand_col_o) == int'($past(cand_col_o)) + 1);

  p_mv_in_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(mv_row_o) >= -int'(RANGE) && int'(mv_row_o) <= int'(RANGE) &&
                int'(mv_col_o) >= -int'(RANGE) && int'(mv_col_o) <= int'(RANGE)));
endmodule

bind me_two_step me_two_step_chk #(.RANGE(RANGE), .MV_W(MV_W), .COST_W(COST_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cand_vld_o  (cand_vld_o),
  .cand_row_o  (cand_row_o),
  .cand_col_o  (cand_col_o),
  .done_o      (done_o),
  .mv_row_o    (mv_row_o),
  .mv_col_o    (mv_col_o),
  .cost_o      (cost_o),
  .not_found_o (not_found_o)
);

// File: tb/test_me_two_step.sv
`timescale 1ns/1ps
module test_me_two_step;
  localparam int BLK    = 4;
  localparam int RANGE  = 4;
  localparam int NUM    = BLK * BLK;
  localparam int WIN    = 2 * RANGE + BLK;
  localparam int COST_W = 8 + $clog2(NUM);
  localparam int MV_W   = $clog2(RANGE + 1) + 1;

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   start_i = 1'b0;
  logic                   mode_i = 1'b0;
  logic [COST_W-1:0]      thresh_i = '0;
  logic [NUM*8-1:0]       cur_blk_i = '0;
  logic [NUM*8-1:0]       ref_blk_i;
  logic                   cand_vld_o, done_o, not_found_o;
  logic signed [MV_W-1:0] cand_row_o, cand_col_o, mv_row_o, mv_col_o;
  logic [COST_W-1:0]      cost_o;

  int cur_pix [NUM];
  int ref_pix [WIN][WIN];
  int q_row[$], q_col[$];
  int exp_row, exp_col, exp_cost;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  me_two_step #(.BLK(BLK), .RANGE(RANGE)) i_me_two_step (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .thresh_i(thresh_i), .cur_blk_i(cur_blk_i), .ref_blk_i(ref_blk_i),
    .cand_vld_o(cand_vld_o), .cand_row_o(cand_row_o), .cand_col_o(cand_col_o),
    .done_o(done_o), .mv_row_o(mv_row_o), .mv_col_o(mv_col_o),
    .cost_o(cost_o), .not_found_o(not_found_o)
  );

  function automatic int clampw(int v);
    return (v < 0) ? 0 : (v > WIN - 1) ? WIN - 1 : v;
  endfunction

  // reference memory answering the candidate request in the same cycle
  always_comb begin
    for (int i = 0; i < NUM; i++)
      ref_blk_i[i*8 +: 8] = 8'(ref_pix[clampw(RANGE + int'(cand_row_o) + i / BLK)]
                                      [clampw(RANGE + int'(cand_col_o) + i % BLK)]);
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int sad_at(int dy, int dx, bit lr);
    int s = 0;
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) begin
        int a = cur_pix[r*BLK+c];
        int b = ref_pix[RANGE+dy+r][RANGE+dx+c];
        if (lr) begin a = a & 8'hC0; b = b & 8'hC0; end
        s += (a > b) ? a - b : b - a;
      end
    return s;
  endfunction

  task automatic model(bit mode);
    int best, br, bc, rlo, rhi, clo, chi, s;
    q_row.delete(); q_col.delete();
    rlo = -RANGE; rhi = RANGE; clo = -RANGE; chi = RANGE;
    if (!mode) begin
      best = -1; br = 0; bc = 0;
      for (int dy = -RANGE; dy <= RANGE; dy++)
        for (int dx = -RANGE; dx <= RANGE; dx++) begin
          q_row.push_back(dy); q_col.push_back(dx);
          s = sad_at(dy, dx, 1'b1);
          if (best < 0 || s < best) begin best = s; br = dy; bc = dx; end
        end
      rlo = (br - 2 < -RANGE) ? -RANGE : br - 2;
      rhi = (br + 2 > RANGE) ? RANGE : br + 2;
      clo = (bc - 2 < -RANGE) ? -RANGE : bc - 2;
      chi = (bc + 2 > RANGE) ? RANGE : bc + 2;
    end
    best = -1;
    for (int dy = rlo; dy <= rhi; dy++)
      for (int dx = clo; dx <= chi; dx++) begin
        q_row.push_back(dy); q_col.push_back(dx);
        s = sad_at(dy, dx, 1'b0);
        if (best < 0 || s < best) begin best = s; exp_row = dy; exp_col = dx; end
      end
    exp_cost = best;
  endtask

  task automatic pack_cur();
    for (int i = 0; i < NUM; i++) cur_blk_i[i*8 +: 8] = 8'(cur_pix[i]);
  endtask

  task automatic fill_rand();
    for (int r = 0; r < WIN; r++)
      for (int c = 0; c < WIN; c++) ref_pix[r][c] = int'($urandom_range(0, 255));
    for (int i = 0; i < NUM; i++) cur_pix[i] = int'($urandom_range(0, 255));
  endtask

  task automatic plant(int dy, int dx);
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++) cur_pix[r*BLK+c] = ref_pix[RANGE+dy+r][RANGE+dx+c];
  endtask

  // drives one search and compares the request stream and the results every cycle
  task automatic run_search(bit mode, int thresh, int inj, string req);
    int n;
    model(mode);
    pack_cur();
    n = q_row.size();
    @(negedge clk);
    start_i = 1'b1; mode_i = mode; thresh_i = COST_W'(thresh);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (k == inj) begin start_i = 1'b1; mode_i = ~mode; end
      if (k == inj + 1) start_i = 1'b0;
      chk(cand_vld_o == 1'b1, "R9", "cand_vld", int'(cand_vld_o), 1);
      chk(int'(cand_row_o) == q_row[k], req, "cand_row", int'(cand_row_o), q_row[k]);
      chk(int'(cand_col_o) == q_col[k], req, "cand_col", int'(cand_col_o), q_col[k]);
      chk(done_o == 1'b0, "R7", "early done", int'(done_o), 0);
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R7", "done pulse", int'(done_o), 1);
    chk(cand_vld_o == 1'b0, "R9", "vld at done", int'(cand_vld_o), 0);
    chk(int'(mv_row_o) == exp_row, "R1", "mv_row", int'(mv_row_o), exp_row);
    chk(int'(mv_col_o) == exp_col, "R1", "mv_col", int'(mv_col_o), exp_col);
    chk(int'(cost_o) == exp_cost, "R1", "cost", int'(cost_o), exp_cost);
    chk(not_found_o == (exp_cost > thresh), "R6", "not_found",
        int'(not_found_o), int'(exp_cost > thresh));
    @(negedge clk);
    chk(done_o == 1'b0, "R7", "done width", int'(done_o), 0);
    repeat (4) @(negedge clk);
    chk(int'(cost_o) == exp_cost, "R7", "cost hold", int'(cost_o), exp_cost);
    chk(int'(mv_row_o) == exp_row && int'(mv_col_o) == exp_col, "R7", "mv hold",
        int'(mv_row_o), exp_row);
    chk(cand_vld_o == 1'b0, "R9", "idle vld", int'(cand_vld_o), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    fill_rand();
    pack_cur();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(cand_vld_o == 1'b0, "R8", "vld", int'(cand_vld_o), 0);
    chk(done_o == 1'b0, "R8", "done", int'(done_o), 0);
    chk(cost_o == '0 && not_found_o == 1'b0, "R8", "cost/nf", int'(cost_o), 0);
    chk(mv_row_o == '0 && mv_col_o == '0, "R8", "mv", int'(mv_row_o), 0);

    // R2 R3 random data, two passes
    run_search(1'b0, 4095, -5, "R2");
    // R4 same data, single full pass
    run_search(1'b1, 4095, -5, "R4");
    // R7 start raised mid-search is ignored
    fill_rand();
    run_search(1'b0, 4095, 10, "R7");

    // R6 exact match: cost 0 against threshold 0 is found
    fill_rand(); plant(3, -1);
    run_search(1'b0, 0, -5, "R1");
    // R6 threshold boundary with a noisy match
    cur_pix[0] = (cur_pix[0] > 250) ? cur_pix[0] - 5 : cur_pix[0] + 5;
    model(1'b0);
    run_search(1'b0, exp_cost - 1, -5, "R6");
    run_search(1'b0, exp_cost, -5, "R6");

    // R5 flat frame: all costs equal, first candidate wins, R3 window clipped at corner
    for (int r = 0; r < WIN; r++) for (int c = 0; c < WIN; c++) ref_pix[r][c] = 100;
    for (int i = 0; i < NUM; i++) cur_pix[i] = 100;
    run_search(1'b0, 0, -5, "R5");
    run_search(1'b1, 0, -5, "R5");

    // R2 only low six bits differ: coarse pass sees no difference anywhere
    for (int r = 0; r < WIN; r++)
      for (int c = 0; c < WIN; c++) ref_pix[r][c] = 8'h40 | int'($urandom_range(0, 63));
    for (int i = 0; i < NUM; i++) cur_pix[i] = 8'h40 | int'($urandom_range(0, 63));
    run_search(1'b0, 4095, -5, "R2");

    // R3 winner at the far corner, refinement clipped on the high side
    fill_rand(); plant(4, 4);
    run_search(1'b0, 10, -5, "R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule